// File: doc/BRIEF.md
# USB Device Endpoint Buffer Controller

This block manages the packet buffers of a USB device-side core. A microprocessor drives it through single-cycle commands. A simplified serial-engine port delivers received bytes and end-of-packet markers, fetches bytes for transmission and reports completed sends. Each endpoint slot has an enable bit, a direction bit, a buffer-full flag, a NAK-seen flag, a stored length and an interrupt bit. The interrupt bits of all slots together form the `ep_irq` vector.

Slot 0 is the control OUT endpoint and slot 1 is the control IN endpoint. Both are always enabled and their direction is fixed. Firmware selects a slot and then works on it. It programs the slot's configuration, streams the buffer out or in through a pointer that starts at the length word, releases a received buffer, arms a transmit buffer, reads the status word, or acknowledges a set-up packet. A set-up packet arriving on slot 0 flushes the control IN buffer. It also locks both control slots against clear and validate until each slot has been acknowledged.

Top module: `usb_ep_buf_ctrl`

## Requirements
- R1: Command code 2 (configure) writes `cpu_wdata[0]` as enable and `cpu_wdata[1]` as direction (1 = IN) into the selected slot when that slot is 2 or higher. The status word reflects the new values.
- R2: `rst_n` low, or `usb_reset` high at a clock edge, clears every slot's configuration, full flag, NAK flag, interrupt bit and set-up lock. Slot 0 stays enabled as OUT and slot 1 stays enabled as IN, and configure commands aimed at them are ignored.
- R3: An accepted received packet sets the receiving slot's interrupt bit at the clock edge that ends the end-of-packet cycle.
- R4: Command code 8 (status) returns on `cpu_rdata` one cycle later, with `cpu_rvalid` high, the word {2'b0, set-up held (slot 0 only), IN, enabled, NAK seen, locked, full}, from bit 7 down to bit 0. It clears the selected slot's interrupt bit and NAK flag.
- R5: On an enabled OUT slot, command code 3 (read buffer) returns the stored length and then the received bytes. Command code 5 (clear) drops the full flag.
- R6: On an enabled IN slot that is not full, command code 4 (write buffer) stores the length and then the data bytes. Command code 6 (validate) sets full. `sie_tx_ready`, `sie_tx_len` and `sie_tx_data` then present the slot addressed by `sie_tx_ep` and byte index `sie_tx_idx`.
- R7: A set-up packet ending on slot 0 is stored even if the buffer is full. It sets the set-up-held bit, drops slot 1's full flag and locks both control slots.
- R8: While a control slot is locked, clear and validate commands aimed at it have no effect. Command code 7 (acknowledge set-up) unlocks only the selected control slot.
- R9: A packet that ends on an enabled OUT slot whose buffer is still full is discarded. The stored length and data stay unchanged, `sie_nak` pulses in the next cycle and the slot's NAK flag is set.
- R10: `sie_tx_done` on a slot that is ready clears its full flag and sets its interrupt bit at the same clock edge.
- R11: Command code 1 (select) loads `cpu_wdata` as the slot number and resets the buffer pointer. The pointer returns the length word first and the data bytes in ascending order afterwards.
- R12: Read buffer, write buffer, clear, validate and received packets aimed at a disabled slot leave that slot's state unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| usb_reset | input | 1 | Bus reset, synchronous |
| cpu_valid | input | 1 | Command strobe |
| cpu_op | input | 4 | Command code |
| cpu_wdata | input | 8 | Command argument or data byte |
| cpu_rvalid | output | 1 | Read data valid |
| cpu_rdata | output | 8 | Read data |
| ep_irq | output | NUM_EP | Per-slot interrupt bits |
| sie_rx_valid | input | 1 | Received byte strobe |
| sie_rx_eop | input | 1 | End of received packet |
| sie_ep | input | EPW | Slot of the received packet |
| sie_setup | input | 1 | Received packet is a set-up packet |
| sie_rx_data | input | 8 | Received byte |
| sie_nak | output | 1 | Packet refused, buffer full |
| sie_tx_ep | input | EPW | Slot addressed for transmission |
| sie_tx_idx | input | PW | Byte index addressed for transmission |
| sie_tx_ready | output | 1 | Addressed slot holds a validated packet |
| sie_tx_len | output | 8 | Length of the addressed packet |
| sie_tx_data | output | 8 | Byte at the addressed index |
| sie_tx_done | input | 1 | Addressed packet has been sent |

## Verification
The bench builds the controller with four slots and four-byte buffers. With that size it can sweep every packet length from zero to full on both OUT slots and both IN slots. The small slot count leaves room for the same run to cover the set-up lock on both control slots, a refused packet, a disabled slot and a bus reset. The expected bytes are computed from the slot number, the length and the byte index.

// File: rtl/usb_ep_buf_ctrl.sv
module usb_ep_buf_ctrl #(
  parameter int NUM_EP  = 16,
  parameter int MAX_PKT = 64,
  localparam int EPW = $clog2(NUM_EP),
  localparam int PW  = $clog2(MAX_PKT + 2)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              usb_reset,
  input  logic              cpu_valid,
  input  logic [3:0]        cpu_op,
  input  logic [7:0]        cpu_wdata,
  output logic              cpu_rvalid,
  output logic [7:0]        cpu_rdata,
  output logic [NUM_EP-1:0] ep_irq,
  input  logic              sie_rx_valid,
  input  logic              sie_rx_eop,
  input  logic [EPW-1:0]    sie_ep,
  input  logic              sie_setup,
  input  logic [7:0]        sie_rx_data,
  output logic              sie_nak,
  input  logic [EPW-1:0]    sie_tx_ep,
  input  logic [PW-1:0]     sie_tx_idx,
  output logic              sie_tx_ready,
  output logic [7:0]        sie_tx_len,
  output logic [7:0]        sie_tx_data,
  input  logic              sie_tx_done
);
  localparam int MD = NUM_EP * MAX_PKT;
  localparam int MW = $clog2(MD);
  localparam logic [PW-1:0] PMAX = PW'(MAX_PKT);

  localparam logic [3:0] OP_SEL = 4'd1, OP_CFG = 4'd2, OP_RD = 4'd3, OP_WR = 4'd4,
                         OP_CLR = 4'd5, OP_VAL = 4'd6, OP_ACK = 4'd7, OP_STAT = 4'd8;

  logic [NUM_EP-1:0] en_q, in_q, full_q, nak_q;
  logic [1:0]        lock_q;
  logic              setup_q;
  logic [EPW-1:0]    sel_q;
  logic [PW-1:0]     ptr_q, rx_cnt_q;
  logic [7:0]        len_q [NUM_EP];
  logic [7:0]        mem_q [MD];

  function automatic logic [MW-1:0] maddr(input logic [EPW-1:0] e, input logic [PW-1:0] i);
    return MW'(e) * MW'(MAX_PKT) + MW'(i);
  endfunction

  logic sel_en, sel_ctrl, sel_lock, wr_ok, rx_ok, tx_ok;
  logic cpu_we, sie_we;
  logic [PW-1:0] ptr_m1;
  logic [7:0] cpu_byte, stat_word;

  assign sel_en   = en_q[sel_q];
  assign sel_ctrl = (sel_q == EPW'(0)) || (sel_q == EPW'(1));
  assign sel_lock = sel_ctrl && lock_q[sel_q[0]];
  assign wr_ok    = sel_en && in_q[sel_q] && !full_q[sel_q];
  assign ptr_m1   = ptr_q - PW'(1);

  assign rx_ok = en_q[sie_ep] && !in_q[sie_ep] &&
                 !(sie_setup && sie_ep != EPW'(0)) &&
                 (!full_q[sie_ep] || (sie_setup && sie_ep == EPW'(0)));

  assign sie_tx_ready = full_q[sie_tx_ep] && en_q[sie_tx_ep] && in_q[sie_tx_ep];
  assign tx_ok        = sie_tx_done && sie_tx_ready;
  assign sie_tx_len   = len_q[sie_tx_ep];
  assign sie_tx_data  = (sie_tx_idx < PMAX) ? mem_q[maddr(sie_tx_ep, sie_tx_idx)] : 8'h00;

  assign cpu_byte = (ptr_q == '0) ? len_q[sel_q] :
                    (ptr_q <= PMAX) ? mem_q[maddr(sel_q, ptr_m1)] : 8'h00;

  assign stat_word = {2'b00, (sel_q == EPW'(0)) && setup_q, in_q[sel_q], en_q[sel_q],
                      nak_q[sel_q], sel_lock, full_q[sel_q]};

  assign cpu_we = cpu_valid && cpu_op == OP_WR && wr_ok && ptr_q != '0 && ptr_q <= PMAX;
  assign sie_we = sie_rx_valid && rx_ok && rx_cnt_q < PMAX;

  always_ff @(posedge clk) begin
    if (cpu_we) mem_q[maddr(sel_q, ptr_m1)] <= cpu_wdata;
    if (sie_we) mem_q[maddr(sie_ep, rx_cnt_q)] <= sie_rx_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q <= NUM_EP'(3);
      in_q <= NUM_EP'(2);
      full_q <= '0;
      nak_q <= '0;
      ep_irq <= '0;
      lock_q <= '0;
      setup_q <= 1'b0;
      sel_q <= '0;
      ptr_q <= '0;
      rx_cnt_q <= '0;
      cpu_rvalid <= 1'b0;
      cpu_rdata <= '0;
      sie_nak <= 1'b0;
      for (int i = 0; i < NUM_EP; i++) len_q[i] <= '0;
    end else if (usb_reset) begin
      en_q <= NUM_EP'(3);
      in_q <= NUM_EP'(2);
      full_q <= '0;
      nak_q <= '0;
      ep_irq <= '0;
      lock_q <= '0;
      setup_q <= 1'b0;
      ptr_q <= '0;
      rx_cnt_q <= '0;
      cpu_rvalid <= 1'b0;
      sie_nak <= 1'b0;
    end else begin
      cpu_rvalid <= 1'b0;
      sie_nak <= 1'b0;
      if (cpu_valid) begin
        case (cpu_op)
          OP_SEL: begin
            sel_q <= cpu_wdata[EPW-1:0];
            ptr_q <= '0;
          end
          OP_CFG: if (!sel_ctrl) begin
            en_q[sel_q] <= cpu_wdata[0];
            in_q[sel_q] <= cpu_wdata[1];
          end
          OP_RD: if (sel_en) begin
            cpu_rvalid <= 1'b1;
            cpu_rdata <= cpu_byte;
            if (ptr_q <= PMAX) ptr_q <= ptr_q + PW'(1);
          end
          OP_WR: if (wr_ok) begin
            if (ptr_q == '0) len_q[sel_q] <= cpu_wdata;
            if (ptr_q <= PMAX) ptr_q <= ptr_q + PW'(1);
          end
          OP_CLR: if (sel_en && !sel_lock) begin
            full_q[sel_q] <= 1'b0;
            if (sel_q == EPW'(0)) setup_q <= 1'b0;
          end
          OP_VAL: if (sel_en && in_q[sel_q] && !sel_lock) full_q[sel_q] <= 1'b1;
          OP_ACK: if (sel_ctrl) lock_q[sel_q[0]] <= 1'b0;
          OP_STAT: begin
            cpu_rvalid <= 1'b1;
            cpu_rdata <= stat_word;
            ep_irq[sel_q] <= 1'b0;
            nak_q[sel_q] <= 1'b0;
          end
          default: ;
        endcase
      end
      if (sie_rx_valid && rx_ok && rx_cnt_q < PMAX) rx_cnt_q <= rx_cnt_q + PW'(1);
      if (sie_rx_eop) begin
        rx_cnt_q <= '0;
        if (rx_ok) begin
          full_q[sie_ep] <= 1'b1;
          len_q[sie_ep] <= 8'(rx_cnt_q);
          ep_irq[sie_ep] <= 1'b1;
          if (sie_ep == EPW'(0)) setup_q <= sie_setup;
          if (sie_setup) begin
            lock_q <= 2'b11;
            full_q[1] <= 1'b0;
          end
        end else if (en_q[sie_ep] && !in_q[sie_ep]) begin
          sie_nak <= 1'b1;
          nak_q[sie_ep] <= 1'b1;
        end
      end
      if (tx_ok) begin
        full_q[sie_tx_ep] <= 1'b0;
        ep_irq[sie_tx_ep] <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/usb_ep_buf_ctrl_chk.sv
module usb_ep_buf_ctrl_chk #(
  parameter int NUM_EP  = 16,
  parameter int MAX_PKT = 64,
  localparam int EPW = $clog2(NUM_EP)
) (
  input logic              clk,
  input logic              rst_n,
  input logic              usb_reset,
  input logic              cpu_valid,
  input logic [3:0]        cpu_op,
  input logic [EPW-1:0]    sel_q,
  input logic [NUM_EP-1:0] full_q,
  input logic [NUM_EP-1:0] en_q,
  input logic [NUM_EP-1:0] in_q,
  input logic [1:0]        lock_q,
  input logic [NUM_EP-1:0] ep_irq,
  input logic              sie_rx_eop,
  input logic              sie_setup,
  input logic [EPW-1:0]    sie_ep,
  input logic              sie_nak,
  input logic              sie_tx_done,
  input logic              sie_tx_ready,
  input logic [EPW-1:0]    sie_tx_ep
);
  localparam logic [3:0] OP_VAL = 4'd6;

  AST_CTRL_FIXED: assert property (@(posedge clk) disable iff (!rst_n)
    en_q[0] && en_q[1] && !in_q[0] && in_q[1]); // R2

  AST_BUS_RESET: assert property (@(posedge clk) disable iff (!rst_n)
    usb_reset |=> (ep_irq == '0 && full_q == '0 && en_q == NUM_EP'(3))); // R2

  AST_SETUP_FLUSH: assert property (@(posedge clk) disable iff (!rst_n || usb_reset)
    (sie_rx_eop && sie_setup && sie_ep == EPW'(0)) |=> (!full_q[1] && lock_q == 2'b11)); // R7

  AST_LOCK_BLOCKS_VAL: assert property (@(posedge clk) disable iff (!rst_n || usb_reset)
    (cpu_valid && cpu_op == OP_VAL && sel_q == EPW'(1) && lock_q[1] && !full_q[1]) |=> !full_q[1]); // R8

  AST_FULL_NAK: assert property (@(posedge clk) disable iff (!rst_n || usb_reset)
    (sie_rx_eop && !sie_setup && en_q[sie_ep] && !in_q[sie_ep] && full_q[sie_ep]) |=> sie_nak); // R9

  AST_TX_IRQ: assert property (@(posedge clk) disable iff (!rst_n || usb_reset)
    (sie_tx_done && sie_tx_ready) |=> (ep_irq[$past(sie_tx_ep)] && !full_q[$past(sie_tx_ep)])); // R10
endmodule

bind usb_ep_buf_ctrl usb_ep_buf_ctrl_chk #(.NUM_EP(NUM_EP), .MAX_PKT(MAX_PKT)) u_chk (.*);

// File: tb/usb_ep_buf_ctrl_tb.sv
`timescale 1ns/1ps
module usb_ep_buf_ctrl_tb;
  localparam int NUM_EP = 4;
  localparam int MAX_PKT = 4;
  localparam int EPW = $clog2(NUM_EP);
  localparam int PW = $clog2(MAX_PKT + 2);

  logic clk = 1'b0, rst_n = 1'b0, usb_reset = 1'b0;
  logic cpu_valid = 1'b0;
  logic [3:0] cpu_op = '0;
  logic [7:0] cpu_wdata = '0;
  logic cpu_rvalid;
  logic [7:0] cpu_rdata;
  logic [NUM_EP-1:0] ep_irq;
  logic sie_rx_valid = 1'b0, sie_rx_eop = 1'b0, sie_setup = 1'b0, sie_tx_done = 1'b0;
  logic [EPW-1:0] sie_ep = '0, sie_tx_ep = '0;
  logic [7:0] sie_rx_data = '0;
  logic [PW-1:0] sie_tx_idx = '0;
  logic sie_nak, sie_tx_ready;
  logic [7:0] sie_tx_len, sie_tx_data;

  int checks = 0, fails = 0;
  logic got_nak;
  logic [7:0] sv;

  always #2.5 clk = ~clk;

  usb_ep_buf_ctrl #(.NUM_EP(NUM_EP), .MAX_PKT(MAX_PKT)) u_dut (.*);

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic cmd(input logic [3:0] op, input logic [7:0] d);
    @(negedge clk);
    cpu_valid = 1'b1; cpu_op = op; cpu_wdata = d;
    @(negedge clk);
    cpu_valid = 1'b0;
  endtask

  task automatic stat(input int ep);
    cmd(4'd1, 8'(ep));
    cmd(4'd8, 8'h00);
    sv = cpu_rdata;
  endtask

  task automatic rx(input int ep, input logic su, input int len, input int base);
    for (int i = 0; i < len; i++) begin
      @(negedge clk);
      sie_rx_valid = 1'b1; sie_ep = EPW'(ep); sie_setup = su; sie_rx_data = 8'(base + i);
    end
    @(negedge clk);
    sie_rx_valid = 1'b0; sie_rx_eop = 1'b1; sie_ep = EPW'(ep); sie_setup = su;
    @(negedge clk);
    sie_rx_eop = 1'b0; sie_setup = 1'b0;
    got_nak = sie_nak;
  endtask

  task automatic tx_done(input int ep);
    @(negedge clk);
    sie_tx_ep = EPW'(ep); sie_tx_done = 1'b1;
    @(negedge clk);
    sie_tx_done = 1'b0;
  endtask

  task automatic tx_ready(input int ep, output logic r);
    sie_tx_ep = EPW'(ep);
    #1;
    r = sie_tx_ready;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    logic r;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R2 irq after reset", int'(ep_irq), 0);
    stat(0); chk("R2 ep0 status", sv, 8'h08);
    stat(1); chk("R2 ep1 status", sv, 8'h18);
    stat(2); chk("R2 ep2 status", sv, 8'h00);
    cmd(4'd1, 8'd1); cmd(4'd2, 8'h00);
    stat(1); chk("R2 ep1 cfg ignored", sv, 8'h18);

    cmd(4'd1, 8'd2); cmd(4'd2, 8'h01);
    cmd(4'd1, 8'd3); cmd(4'd2, 8'h03);
    stat(2); chk("R1 ep2 OUT enabled", sv, 8'h08);
    stat(3); chk("R1 ep3 IN enabled", sv, 8'h18);

    for (int e = 0; e <= 2; e += 2) begin
      for (int len = 0; len <= MAX_PKT; len++) begin
        int base = e * 32 + len * 5;
        rx(e, 1'b0, len, base);
        chk("R3 irq on receive", int'(ep_irq[e]), 1);
        stat(e);
        chk("R4 status full", sv, 8'h09);
        chk("R4 irq cleared by status", int'(ep_irq[e]), 0);
        cmd(4'd1, 8'(e));
        cmd(4'd3, 8'h00);
        chk("R5 R11 length first", cpu_rdata, len);
        for (int i = 0; i < len; i++) begin
          cmd(4'd3, 8'h00);
          chk("R5 R11 data ascending", cpu_rdata, 8'(base + i));
        end
        cmd(4'd5, 8'h00);
        stat(e); chk("R5 clear drops full", sv, 8'h08);
      end
    end

    rx(2, 1'b0, 3, 8'h40);
    rx(2, 1'b0, 2, 8'h90);
    chk("R9 nak pulse", int'(got_nak), 1);
    stat(2); chk("R9 status nak", sv, 8'h0D);
    stat(2); chk("R4 nak cleared by status", sv, 8'h09);
    cmd(4'd1, 8'd2);
    cmd(4'd3, 8'h00); cmd(4'd3, 8'h00);
    chk("R9 old data kept", cpu_rdata, 8'h40);
    cmd(4'd1, 8'd2);
    cmd(4'd3, 8'h00);
    chk("R11 pointer reset on select", cpu_rdata, 3);
    cmd(4'd5, 8'h00);

    for (int e = 1; e <= 3; e += 2) begin
      for (int len = 0; len <= MAX_PKT; len++) begin
        cmd(4'd1, 8'(e));
        cmd(4'd4, 8'(len));
        for (int i = 0; i < len; i++) cmd(4'd4, 8'(e * 16 + len + i));
        tx_ready(e, r); chk("R6 not ready before validate", int'(r), 0);
        cmd(4'd6, 8'h00);
        tx_ready(e, r); chk("R6 ready after validate", int'(r), 1);
        chk("R6 tx length", sie_tx_len, len);
        for (int i = 0; i < len; i++) begin
          sie_tx_idx = PW'(i);
          #1;
          chk("R6 tx data", sie_tx_data, 8'(e * 16 + len + i));
        end
        tx_done(e);
        tx_ready(e, r); chk("R10 full dropped", int'(r), 0);
        chk("R10 irq set", int'(ep_irq[e]), 1);
        stat(e); chk("R10 status after send", sv, 8'h18);
      end
    end

    cmd(4'd1, 8'd3); cmd(4'd2, 8'h00);
    cmd(4'd4, 8'd2); cmd(4'd4, 8'hAA); cmd(4'd6, 8'h00); cmd(4'd5, 8'h00);
    rx(3, 1'b0, 2, 8'h11);
    chk("R12 no irq on disabled", int'(ep_irq[3]), 0);
    chk("R12 no nak on disabled", int'(got_nak), 0);
    stat(3); chk("R12 disabled status", sv, 8'h00);
    cmd(4'd1, 8'd3); cmd(4'd2, 8'h03);
    cmd(4'd1, 8'd3); cmd(4'd3, 8'h00);
    chk("R12 length untouched", cpu_rdata, MAX_PKT);
    tx_ready(3, r); chk("R12 not validated", int'(r), 0);

    cmd(4'd1, 8'd1); cmd(4'd4, 8'd1); cmd(4'd4, 8'h55); cmd(4'd6, 8'h00);
    tx_ready(1, r); chk("R6 ep1 armed", int'(r), 1);
    rx(0, 1'b1, 3, 8'h70);
    tx_ready(1, r); chk("R7 ep1 flushed", int'(r), 0);
    stat(0); chk("R7 ep0 setup locked", sv, 8'h2B);
    stat(1); chk("R7 ep1 locked", sv, 8'h1A);
    cmd(4'd1, 8'd0); cmd(4'd5, 8'h00);
    stat(0); chk("R8 clear refused", sv, 8'h2B);
    cmd(4'd1, 8'd1); cmd(4'd4, 8'd1); cmd(4'd4, 8'h66); cmd(4'd6, 8'h00);
    tx_ready(1, r); chk("R8 validate refused", int'(r), 0);
    cmd(4'd1, 8'd0); cmd(4'd7, 8'h00); cmd(4'd5, 8'h00);
    stat(0); chk("R8 clear after ack", sv, 8'h08);
    cmd(4'd1, 8'd1); cmd(4'd6, 8'h00);
    tx_ready(1, r); chk("R8 ep1 still locked", int'(r), 0);
    cmd(4'd7, 8'h00); cmd(4'd6, 8'h00);
    tx_ready(1, r); chk("R8 validate after ack", int'(r), 1);
    sie_tx_idx = '0; #1;
    chk("R8 ep1 data", sie_tx_data, 8'h66);

    rx(2, 1'b0, 1, 8'h21);
    @(negedge clk); usb_reset = 1'b1;
    @(negedge clk); usb_reset = 1'b0;
    chk("R2 irq cleared by bus reset", int'(ep_irq), 0);
    tx_ready(1, r); chk("R2 ep1 not full", int'(r), 0);
    stat(2); chk("R2 ep2 config cleared", sv, 8'h00);
    stat(0); chk("R2 ep0 still enabled", sv, 8'h08);
    stat(1); chk("R2 ep1 still enabled", sv, 8'h18);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule